// File: doc/BRIEF.md
# Byte Execution Unit with Status Flags

This block is the data path of a small byte-wide processor core. It takes a four-bit operation code, a destination operand, a source operand and the six current status flags. It produces the new destination value, the new flag set, and a write-back enable that says whether the destination register should be overwritten. The operations are subtract and subtract-with-borrow, four rotates, arithmetic shift right, nibble swap, exclusive-or, two bit-test operations and carry set and clear.

Each operation has its own flag rule. A flag is recomputed, forced to a constant, or passed through from the input. The test operations only report flags; they never request a write. Flags that an operation leaves undefined are passed through unchanged, so every output is deterministic. All the arithmetic and logic is combinational. A thin register stage latches the result, flags and write enable, so everything appears one clock after the inputs are presented.

Flag vector layout, used on both `flags_i` and `flags_q`: bit 5 = C (carry/borrow), bit 4 = Z (zero), bit 3 = S (sign), bit 2 = V (overflow), bit 1 = D (decimal-adjust marker), bit 0 = H (half carry).

Top module: `byte_exec_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next outputs are `result_q`=0, `flags_q`=0 and `wr_q`=0.
- R2: Inputs sampled at a rising edge appear on `result_q`, `flags_q` and `wr_q` after that same edge and hold until the next edge. The flag layout is C=bit5, Z=bit4, S=bit3, V=bit2, D=bit1, H=bit0.
- R3: Code 0x0 forces C to 0 and code 0x1 forces C to 1. For both codes the other five flags pass through, `result_q` equals dst and `wr_q` is 0.
- R4: Code 0x4 rotates left (bit 7 goes into bit 0) and code 0x5 rotates left through carry (C goes into bit 0). In both, C receives old bit 7. Code 0x8 rotates right (bit 0 goes into bit 7) and code 0x9 rotates right through carry (C goes into bit 7). In both, C receives old bit 0. For all four rotates, Z and S follow the result, V = result bit 7 XOR operand bit 7, D and H pass through, and `wr_q` is 1.
- R5: Code 0xA shifts right arithmetically: bit 7 is kept and C receives old bit 0. Z and S follow the result, V is 0, D and H pass through, and `wr_q` is 1.
- R6: Code 0x2 writes dst minus src. C is 1 on a borrow out of bit 7. V is 1 on signed overflow. Z and S follow the result. `wr_q` is 1.
- R7: Code 0x3 writes dst minus src minus the input C, with the same flag rules as R6.
- R8: For codes 0x2 and 0x3, D is forced to 1, and H is 1 exactly when the low nibble subtraction (including the incoming borrow for 0x3) borrows out of bit 3.
- R9: Code 0xC exchanges the nibbles of dst and writes the result. Z and S follow the result, while C, V, D and H pass through.
- R10: Code 0xB writes dst XOR src. Z and S follow the result, V is 0, C, D and H pass through, and `wr_q` is 1.
- R11: Code 0x7 tests dst AND src and code 0x6 tests (NOT dst) AND src. Z and S follow the tested value, V is 0, C, D and H pass through, `wr_q` is 0 and `result_q` equals dst.
- R12: Codes 0xD, 0xE and 0xF do nothing: `result_q` equals dst, all flags pass through and `wr_q` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_i | input | 4 | Operation code |
| dst_i | input | W (8) | Destination operand |
| src_i | input | W (8) | Source operand |
| flags_i | input | 6 | Current flags {C,Z,S,V,D,H} |
| result_q | output | W (8) | Registered result value |
| flags_q | output | 6 | Registered new flags {C,Z,S,V,D,H} |
| wr_q | output | 1 | Registered write-back enable |

## Verification
The assertions compare each registered output with the operation code and operands that were sampled one edge earlier. They assume the inputs are at known values on every rising edge, including the unused codes 0xD to 0xF. They also assume that the first sample after reset is not paired with inputs taken while reset was still asserted. The stimulus changes inputs only on falling edges and never leaves them undriven. It walks every destination value through each single-operand code and sends random operands and flags through the two-operand codes and the unused codes. Directed subtract cases cover borrow out of bit 7, borrow out of bit 3 and signed overflow.

// File: rtl/bxu_pkg.sv
// Package: shared operation codes and flag layout for the byte execution unit.
// Assumes: flag vectors are always {C,Z,S,V,D,H}, with C in the top bit.
package bxu_pkg;

    localparam int OPW    = 4;
    localparam int NFLAGS = 6;

    // Operation codes; the subtract and test codes match the two-operand group nibble
    localparam logic [OPW-1:0] OP_CLRC = 4'h0;
    localparam logic [OPW-1:0] OP_SETC = 4'h1;
    localparam logic [OPW-1:0] OP_SUB  = 4'h2;
    localparam logic [OPW-1:0] OP_SBC  = 4'h3;
    localparam logic [OPW-1:0] OP_ROL  = 4'h4;
    localparam logic [OPW-1:0] OP_ROLC = 4'h5;
    localparam logic [OPW-1:0] OP_TSTC = 4'h6;
    localparam logic [OPW-1:0] OP_TST  = 4'h7;
    localparam logic [OPW-1:0] OP_ROR  = 4'h8;
    localparam logic [OPW-1:0] OP_RORC = 4'h9;
    localparam logic [OPW-1:0] OP_ASR  = 4'hA;
    localparam logic [OPW-1:0] OP_XOR  = 4'hB;
    localparam logic [OPW-1:0] OP_SWP  = 4'hC;

    // Bit positions inside a flag vector
    localparam int FC = 5;
    localparam int FZ = 4;
    localparam int FS = 3;
    localparam int FV = 2;
    localparam int FD = 1;
    localparam int FH = 0;

    typedef struct packed {
        logic c;
        logic z;
        logic s;
        logic v;
        logic d;
        logic h;
    } flags_t;

endpackage

// File: rtl/bxu_shift.sv
// Module: rotate and arithmetic-shift unit.
// Does:    the four rotates and the arithmetic right shift, plus their flags.
// Assumes: the caller selects this output only for the rotate/shift codes;
//          for other codes the output is a harmless pass-through.
module bxu_shift
    import bxu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [OPW-1:0] op,
    input  logic [W-1:0]   dst,
    input  flags_t         fin,
    output logic [W-1:0]   res,
    output flags_t         fout
);

    localparam int MSB = W - 1;

    logic cout;

    // Form the moved value and the bit that drops out
    always_comb begin
        res  = dst;
        cout = fin.c;
        case (op)
            OP_ROL:  begin res = {dst[MSB-1:0], dst[MSB]}; cout = dst[MSB]; end
            OP_ROLC: begin res = {dst[MSB-1:0], fin.c};    cout = dst[MSB]; end
            OP_ROR:  begin res = {dst[0], dst[MSB:1]};     cout = dst[0];   end
            OP_RORC: begin res = {fin.c, dst[MSB:1]};      cout = dst[0];   end
            OP_ASR:  begin res = {dst[MSB], dst[MSB:1]};   cout = dst[0];   end
            default: ;
        endcase
    end

    // Derive flags; D and H are carried through
    always_comb begin
        fout   = fin;
        fout.c = cout;
        fout.z = ~|res;
        fout.s = res[MSB];
        fout.v = (op == OP_ASR) ? 1'b0 : (res[MSB] ^ dst[MSB]);
    end

endmodule

// File: rtl/bxu_sub.sv
// Module: subtractor with borrow-in.
// Does:    dst - src - bin, with full, half and signed-overflow borrow flags.
// Assumes: bin is already gated to zero for the plain subtract.
module bxu_sub
    import bxu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] dst,
    input  logic [W-1:0] src,
    input  logic         bin,
    output logic [W-1:0] res,
    output flags_t       fout
);

    localparam int MSB  = W - 1;
    localparam int HALF = W / 2;

    logic [W:0]    full_diff;
    logic [HALF:0] low_diff;

    // Full-width and low-nibble differences; the top bit of each is the borrow
    always_comb begin
        full_diff = {1'b0, dst} - {1'b0, src} - {{W{1'b0}}, bin};
        low_diff  = {1'b0, dst[HALF-1:0]} - {1'b0, src[HALF-1:0]} - {{HALF{1'b0}}, bin};
    end

    // Assemble the result and every flag, D forced high
    always_comb begin
        res    = full_diff[MSB:0];
        fout.c = full_diff[W];
        fout.z = ~|full_diff[MSB:0];
        fout.s = full_diff[MSB];
        fout.v = (dst[MSB] ^ src[MSB]) & (full_diff[MSB] ^ dst[MSB]);
        fout.d = 1'b1;
        fout.h = low_diff[HALF];
    end

endmodule

// File: rtl/bxu_logic.sv
// Module: bitwise unit.
// Does:    exclusive-or, nibble swap and the two mask tests.
// Assumes: the mask tests report flags only; their result output carries dst
//          and their write enable is low.
module bxu_logic
    import bxu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [OPW-1:0] op,
    input  logic [W-1:0]   dst,
    input  logic [W-1:0]   src,
    input  flags_t         fin,
    output logic [W-1:0]   res,
    output flags_t         fout,
    output logic           wr
);

    localparam int MSB  = W - 1;
    localparam int HALF = W / 2;

    logic [W-1:0] probe;

    // Choose the value to write and the value the flags describe
    always_comb begin
        res   = dst;
        probe = dst;
        wr    = 1'b0;
        case (op)
            OP_XOR:  begin res = dst ^ src; probe = dst ^ src; wr = 1'b1; end
            OP_SWP:  begin
                res   = {dst[HALF-1:0], dst[MSB:HALF]};
                probe = {dst[HALF-1:0], dst[MSB:HALF]};
                wr    = 1'b1;
            end
            OP_TST:  probe = dst & src;
            OP_TSTC: probe = ~dst & src;
            default: ;
        endcase
    end

    // Z and S from the probe; V cleared except for the swap
    always_comb begin
        fout   = fin;
        fout.z = ~|probe;
        fout.s = probe[MSB];
        if (op != OP_SWP) begin
            fout.v = 1'b0;
        end
    end

endmodule

// File: rtl/bxu_core.sv
// Module: combinational core.
// Does:    runs all units in parallel and selects one by the operation code.
// Assumes: unused codes mean no operation (dst passed, flags held, no write).
module bxu_core
    import bxu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [OPW-1:0] op,
    input  logic [W-1:0]   dst,
    input  logic [W-1:0]   src,
    input  flags_t         fin,
    output logic [W-1:0]   res,
    output flags_t         fout,
    output logic           wr
);

    logic [W-1:0] sh_res, sb_res, lg_res;
    flags_t       sh_f, sb_f, lg_f;
    logic         lg_wr;
    logic         borrow_in;

    // Borrow enters only for subtract-with-borrow
    always_comb borrow_in = (op == OP_SBC) & fin.c;

    bxu_shift #(.W(W)) u_shift (
        .op(op), .dst(dst), .fin(fin), .res(sh_res), .fout(sh_f)
    );

    bxu_sub #(.W(W)) u_sub (
        .dst(dst), .src(src), .bin(borrow_in), .res(sb_res), .fout(sb_f)
    );

    bxu_logic #(.W(W)) u_logic (
        .op(op), .dst(dst), .src(src), .fin(fin),
        .res(lg_res), .fout(lg_f), .wr(lg_wr)
    );

    // Route the selected unit to the outputs
    always_comb begin
        res  = dst;
        fout = fin;
        wr   = 1'b0;
        case (op)
            OP_CLRC: fout.c = 1'b0;
            OP_SETC: fout.c = 1'b1;
            OP_SUB, OP_SBC: begin
                res = sb_res; fout = sb_f; wr = 1'b1;
            end
            OP_ROL, OP_ROLC, OP_ROR, OP_RORC, OP_ASR: begin
                res = sh_res; fout = sh_f; wr = 1'b1;
            end
            OP_XOR, OP_SWP, OP_TST, OP_TSTC: begin
                res = lg_res; fout = lg_f; wr = lg_wr;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/byte_exec_unit.sv
// Module: top of the byte execution unit.
// Does:    registers the combinational core outputs once per clock.
// Assumes: synchronous active-low reset; inputs are stable around the rising edge.
module byte_exec_unit
    import bxu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OPW-1:0]    op_i,
    input  logic [W-1:0]      dst_i,
    input  logic [W-1:0]      src_i,
    input  logic [NFLAGS-1:0] flags_i,
    output logic [W-1:0]      result_q,
    output logic [NFLAGS-1:0] flags_q,
    output logic              wr_q
);

    logic [W-1:0] core_res;
    flags_t       core_f;
    logic         core_wr;

    bxu_core #(.W(W)) u_core (
        .op(op_i), .dst(dst_i), .src(src_i), .fin(flags_t'(flags_i)),
        .res(core_res), .fout(core_f), .wr(core_wr)
    );

    // Output register with synchronous clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            flags_q  <= '0;
            wr_q     <= 1'b0;
        end else begin
            result_q <= core_res;
            flags_q  <= core_f;
            wr_q     <= core_wr;
        end
    end

endmodule

// Module: property checker for byte_exec_unit.
// Assumes: inputs are known at every rising edge; checks start one edge after
//          reset is released so that outputs always match the previous inputs.
module bxu_checker
    import bxu_pkg::*;
#(
    parameter int W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [OPW-1:0]    op_i,
    input logic [W-1:0]      dst_i,
    input logic [W-1:0]      src_i,
    input logic [NFLAGS-1:0] flags_i,
    input logic [W-1:0]      result_q,
    input logic [NFLAGS-1:0] flags_q,
    input logic              wr_q
);

    logic armed;

    // Marks edges whose previous edge was outside reset
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (result_q == '0 && flags_q == '0 && !wr_q)); // R1

    AST_CARRY_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(op_i) == OP_CLRC) |->
        (!flags_q[FC] && flags_q[FZ:FH] == $past(flags_i[FZ:FH]) && !wr_q)); // R3

    AST_CARRY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(op_i) == OP_SETC) |->
        (flags_q[FC] && flags_q[FZ:FH] == $past(flags_i[FZ:FH]) && !wr_q)); // R3

    AST_ROTATE_KEEPS_DH: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && ($past(op_i) == OP_ROL || $past(op_i) == OP_ROLC ||
                   $past(op_i) == OP_ROR || $past(op_i) == OP_RORC)) |->
        (flags_q[FD:FH] == $past(flags_i[FD:FH]) && wr_q)); // R4

    AST_SHIFT_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(op_i) == OP_ASR) |->
        (!flags_q[FV] && result_q[W-1] == $past(dst_i[W-1]))); // R5

    AST_SUB_DECIMAL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && ($past(op_i) == OP_SUB || $past(op_i) == OP_SBC)) |->
        (flags_q[FD] && wr_q)); // R8

    AST_SWAP_KEEPS_CV: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(op_i) == OP_SWP) |->
        (flags_q[FC] == $past(flags_i[FC]) && flags_q[FV] == $past(flags_i[FV]))); // R9

    AST_ZERO_TRACKS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && wr_q) |-> (flags_q[FZ] == (result_q == '0))); // R10

    AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && ($past(op_i) == OP_TST || $past(op_i) == OP_TSTC)) |->
        (!wr_q && result_q == $past(dst_i) && !flags_q[FV] &&
         flags_q[FC] == $past(flags_i[FC]))); // R11

    AST_UNUSED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(op_i) > OP_SWP) |->
        (!wr_q && flags_q == $past(flags_i) && result_q == $past(dst_i))); // R12

endmodule

bind byte_exec_unit bxu_checker #(.W(W)) u_bxu_checker (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .dst_i(dst_i), .src_i(src_i),
    .flags_i(flags_i), .result_q(result_q), .flags_q(flags_q), .wr_q(wr_q)
);

// File: tb/byte_exec_unit_bench.sv
`timescale 1ns/1ps
// Bench: directed corners plus seeded random stimulus against a bench model.
module byte_exec_unit_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_i = 4'h0;
    logic [7:0] dst_i = 8'h00;
    logic [7:0] src_i = 8'h00;
    logic [5:0] flags_i = 6'h00;
    logic [7:0] result_q;
    logic [5:0] flags_q;
    logic       wr_q;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;

    // 125 MHz clock
    always #4 clk = ~clk;

    byte_exec_unit #(.W(8)) u_byte_exec_unit (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .dst_i(dst_i), .src_i(src_i),
        .flags_i(flags_i), .result_q(result_q), .flags_q(flags_q), .wr_q(wr_q)
    );

    // Expected {wr, flags, result} from the requirements
    function automatic logic [14:0] model(input logic [3:0] op, input logic [7:0] d,
                                          input logic [7:0] s, input logic [5:0] f);
        logic [7:0] r;
        logic [5:0] o;
        logic       w;
        int ci, full, low, sd, ss, tv;
        r = d; o = f; w = 1'b0; ci = int'(f[5]);
        case (op)
            4'h0: o[5] = 1'b0;
            4'h1: o[5] = 1'b1;
            4'h2, 4'h3: begin
                if (op == 4'h2) ci = 0;
                full = int'(d) - int'(s) - ci;
                low  = int'(d % 8'd16) - int'(s % 8'd16) - ci;
                sd   = (d >= 8'd128) ? int'(d) - 256 : int'(d);
                ss   = (s >= 8'd128) ? int'(s) - 256 : int'(s);
                tv   = sd - ss - ci;
                r    = 8'((full + 256) % 256);
                o[5] = (full < 0);
                o[2] = (tv > 127) || (tv < -128);
                o[1] = 1'b1;
                o[0] = (low < 0);
                w    = 1'b1;
            end
            4'h4, 4'h5, 4'h8, 4'h9, 4'hA: begin
                case (op)
                    4'h4: r = 8'((int'(d) * 2) % 256 + int'(d) / 128);
                    4'h5: r = 8'((int'(d) * 2) % 256 + ci);
                    4'h8: r = 8'(int'(d) / 2 + (int'(d) % 2) * 128);
                    4'h9: r = 8'(int'(d) / 2 + ci * 128);
                    default: r = 8'(int'(d) / 2 + ((d >= 8'd128) ? 128 : 0));
                endcase
                o[5] = (op == 4'h4 || op == 4'h5) ? (d >= 8'd128) : d[0];
                o[2] = (op == 4'hA) ? 1'b0 : ((r >= 8'd128) != (d >= 8'd128));
                w    = 1'b1;
            end
            4'h6, 4'h7: begin
                tv   = (op == 4'h7) ? int'(d & s) : int'((8'hFF - d) & s);
                o[4] = (tv == 0);
                o[3] = (tv >= 128);
                o[2] = 1'b0;
            end
            4'hB: begin r = d ^ s; o[2] = 1'b0; w = 1'b1; end
            4'hC: begin r = 8'(int'(d % 8'd16) * 16 + int'(d / 8'd16)); w = 1'b1; end
            default: ;
        endcase
        if (w) begin
            o[4] = (r == 8'h00);
            o[3] = (r >= 8'd128);
        end
        return {w, o, r};
    endfunction

    // Requirement tag per operation code
    function automatic string op_tag(input logic [3:0] op);
        case (op)
            4'h0, 4'h1:               return "R3";
            4'h4, 4'h5, 4'h8, 4'h9:   return "R4";
            4'hA:                     return "R5";
            4'h2:                     return "R6";
            4'h3:                     return "R7";
            4'hC:                     return "R9";
            4'hB:                     return "R10";
            4'h6, 4'h7:               return "R11";
            default:                  return "R12";
        endcase
    endfunction

    task automatic check(input string tag, input logic [14:0] got, input logic [14:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Drive one vector on a falling edge, compare one edge later
    task automatic run_vec(input logic [3:0] op, input logic [7:0] d, input logic [7:0] s,
                           input logic [5:0] f, input string tag);
        @(negedge clk);
        op_i = op; dst_i = d; src_i = s; flags_i = f;
        @(negedge clk);
        check(tag, {wr_q, flags_q, result_q}, model(op, d, s, f));
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog: an expired run is a failure
    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog R2 got=timeout exp=finished");
            report();
        end
    end

    initial begin : stim
        logic [3:0] two_ops [5];
        logic [3:0] one_ops [8];
        two_ops = '{4'h2, 4'h3, 4'h6, 4'h7, 4'hB};
        one_ops = '{4'h0, 4'h1, 4'h4, 4'h5, 4'h8, 4'h9, 4'hA, 4'hC};
        void'($urandom(32'd20240611));

        // R1: reset state with busy inputs
        op_i = 4'h1; dst_i = 8'hA5; src_i = 8'h3C; flags_i = 6'h3F;
        repeat (3) @(negedge clk);
        check("R1", {wr_q, flags_q, result_q}, 15'h0);
        rst_n = 1'b1;

        // R2: output holds until the next edge, then shows the new vector
        run_vec(4'hB, 8'h0F, 8'hF0, 6'h00, "R10");
        @(negedge clk);
        op_i = 4'h2; dst_i = 8'h10; src_i = 8'h01; flags_i = 6'h00;
        #1;
        check("R2", {wr_q, flags_q, result_q}, model(4'hB, 8'h0F, 8'hF0, 6'h00));
        @(negedge clk);
        check("R2", {wr_q, flags_q, result_q}, model(4'h2, 8'h10, 8'h01, 6'h00));

        // Directed subtract corners: borrow bit 3, borrow bit 7, overflow
        run_vec(4'h2, 8'h10, 8'h01, 6'h00, "R8");
        run_vec(4'h2, 8'h00, 8'h01, 6'h00, "R6");
        run_vec(4'h2, 8'h80, 8'h01, 6'h00, "R6");
        run_vec(4'h2, 8'h7F, 8'hFF, 6'h3F, "R6");
        run_vec(4'h2, 8'h55, 8'h55, 6'h00, "R6");
        run_vec(4'h3, 8'h00, 8'h00, 6'h20, "R8");
        run_vec(4'h3, 8'h20, 8'h0F, 6'h20, "R7");
        run_vec(4'h3, 8'h20, 8'h0F, 6'h00, "R7");
        run_vec(4'h6, 8'hFF, 8'h0F, 6'h3F, "R11");
        run_vec(4'h7, 8'h80, 8'h80, 6'h00, "R11");
        run_vec(4'hB, 8'h5A, 8'h5A, 6'h3F, "R10");

        // Every destination value through each single-operand code
        foreach (one_ops[k]) begin
            for (int d = 0; d < 256; d++) begin
                run_vec(one_ops[k], 8'(d), 8'($urandom), 6'($urandom), op_tag(one_ops[k]));
            end
        end

        // Random operands and flags through the two-operand codes
        for (int n = 0; n < 4000; n++) begin
            logic [3:0] op;
            op = two_ops[$urandom % 5];
            run_vec(op, 8'($urandom), 8'($urandom), 6'($urandom), op_tag(op));
        end

        // Unused codes do nothing
        for (int n = 0; n < 30; n++) begin
            logic [3:0] op;
            op = 4'hD + 4'($urandom % 3);
            run_vec(op, 8'($urandom), 8'($urandom), 6'($urandom), "R12");
        end

        // R1: reset asserted mid-run clears the outputs
        @(negedge clk);
        rst_n = 1'b0; op_i = 4'h1; flags_i = 6'h3F;
        @(negedge clk);
        check("R1", {wr_q, flags_q, result_q}, 15'h0);
        rst_n = 1'b1;
        run_vec(4'h4, 8'h81, 8'h00, 6'h00, "R4");

        done = 1'b1;
        report();
    end

endmodule